// File: doc/BRIEF.md
# Dual-Supply Undervoltage Qualifier and Output Gate

This block sits between a half-bridge gate driver's deadtime stage and its output stages. It takes two raw comparator bits, one for the logic/low-side supply and one for the floating high-side supply, where 1 means the supply is above its threshold. Each bit is resynchronised to the block clock. A dropout filter then ignores short negative-going dips and accepts a return to good at once. The two qualified "supply good" levels gate the high-side and low-side commands on their way to the output stages.

The two sides recover differently. The low-side output resumes the current level of its command as soon as the logic supply is good again. The high-side output is disarmed whenever its own supply is bad, and it re-arms only on a fresh rising edge of its command. While the logic supply is in undervoltage, the block raises a fault flag. This includes the power-up interval, and the flag clears once the supply is qualified good. The filter spans are set in nanoseconds and turned into cycle counts from the clock period.

Top module: `dual_supply_uvlo`

## Requirements
- R1: During and right after reset, both gate outputs are 0 and the fault flag is 1. Both supplies are treated as bad until their comparators report good.
- R2: One cycle after the logic supply is qualified bad, both gate outputs are 0.
- R3: A logic-supply dip shorter than LV_DROP_NS/CLK_PERIOD_NS (rounded up, LV_N) consecutive cycles does not disturb the outputs. A dip of LV_N cycles counts as an undervoltage. Its effect appears at the outputs SYNC_STAGES+1 cycles after the LV_N-th bad cycle.
- R4: A qualified high-side undervoltage forces the high-side gate to 0 and leaves the low-side gate and the fault flag unchanged.
- R5: A high-side dip shorter than HV_N = ceil(HV_DROP_NS/CLK_PERIOD_NS) cycles is ignored. A dip of HV_N cycles is an undervoltage.
- R6: After the high-side supply becomes good (at power-up or after an undervoltage), the high-side gate stays 0 until a 0-to-1 transition of the high-side command is sampled. A command held high through the recovery does not drive the gate.
- R7: When the logic supply becomes good, the low-side gate takes the present low-side command level without needing an edge.
- R8: The fault flag is 1 exactly while the logic supply is qualified bad, one cycle delayed, including during power-up.
- R9: A single good comparator sample restores the supply-good state without filtering.
- R10: With both supplies good, each gate output follows its command one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lv_cmp_ok | input | 1 | Raw logic-supply comparator, 1 = above threshold |
| hv_cmp_ok | input | 1 | Raw high-side supply comparator, 1 = above threshold |
| hi_cmd | input | 1 | High-side command from the deadtime stage |
| lo_cmd | input | 1 | Low-side command from the deadtime stage |
| hi_gate | output | 1 | Qualified high-side gate drive, registered |
| lo_gate | output | 1 | Qualified low-side gate drive, registered |
| lv_fault | output | 1 | Logic-supply undervoltage flag, registered |

## Verification
The embedded properties watch several things on every cycle. Both gates must be off after a bad logic supply, and the high gate off after a bad high supply. The fault flag must track the qualified logic supply. Each filter must hold through short dips, drop on the last allowed count and recover on one good sample. The high-side arm must not permit drive on a recovery cycle that has no command edge. Other behaviours show only in the bench's scenarios against its reference model: the exact end-to-end latency through the synchroniser and filter, a dip one cycle short of the limit versus one at the limit, the command held high across a high-side recovery, and the low side resuming a steady command level.

// File: rtl/uvq_pkg.sv
package uvq_pkg;

  // Round a time span up to a whole number of clock cycles.
  function automatic int unsigned span_cycles(input int unsigned span_ns,
                                              input int unsigned period_ns);
    return (span_ns + period_ns - 1) / period_ns;
  endfunction

  typedef struct packed {
    logic lv;
    logic hv;
  } supply_flags_t;

endpackage

// File: rtl/uvq_sync.sv
module uvq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            stage_q[i] <= 1'b0;   // reset reads as "supply bad"
          end else if (i == 0) begin
            stage_q[i] <= d_i;
          end else begin
            stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
          end
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/uvq_dropout_filter.sv
module uvq_dropout_filter #(
  parameter int unsigned LIMIT = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic ok_i,
  output logic good_o
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] run_q;
  logic          good_q;

  // Negative-going runs are counted, positive returns are taken at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      good_q <= 1'b0;
      run_q  <= '0;
    end else if (ok_i) begin
      good_q <= 1'b1;
      run_q  <= '0;
    end else if (run_q == LAST) begin
      good_q <= 1'b0;
    end else begin
      run_q  <= run_q + 1'b1;
    end
  end

  assign good_o = good_q;

  AST_SHORT_DIP_HELD: assert property (@(posedge clk) disable iff (rst)
    (good_q && !ok_i && run_q < LAST) |=> good_q);   // R3, R5
  AST_FULL_DIP_DROPS: assert property (@(posedge clk) disable iff (rst)
    (!ok_i && run_q == LAST) |=> !good_q);           // R3, R5
  AST_FAST_RECOVERY: assert property (@(posedge clk) disable iff (rst)
    ok_i |=> good_q);                                // R9

endmodule

// File: rtl/uvq_hs_arm.sv
module uvq_hs_arm (
  input  logic clk,
  input  logic rst,
  input  logic hv_good_i,
  input  logic cmd_i,
  output logic permit_o
);

  logic armed_q;
  logic cmd_prev_q;
  logic rise;

  assign rise     = cmd_i & ~cmd_prev_q;
  assign permit_o = hv_good_i & (armed_q | rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      cmd_prev_q <= 1'b0;
    end else begin
      armed_q    <= permit_o;   // cleared by a bad supply, set by an edge
      cmd_prev_q <= cmd_i;
    end
  end

  AST_REARM_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($rose(hv_good_i) && !(cmd_i && !cmd_prev_q)) |-> !permit_o);   // R6
  AST_DISARM_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
    !hv_good_i |=> !armed_q);                                       // R6

endmodule

// File: rtl/dual_supply_uvlo.sv
module dual_supply_uvlo #(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned LV_DROP_NS    = 1500,
  parameter int unsigned HV_DROP_NS    = 1300,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lv_cmp_ok,
  input  logic hv_cmp_ok,
  input  logic hi_cmd,
  input  logic lo_cmd,
  output logic hi_gate,
  output logic lo_gate,
  output logic lv_fault
);

  import uvq_pkg::*;

  localparam int unsigned LV_N = (span_cycles(LV_DROP_NS, CLK_PERIOD_NS) < 1) ? 1
                                 : span_cycles(LV_DROP_NS, CLK_PERIOD_NS);
  localparam int unsigned HV_N = (span_cycles(HV_DROP_NS, CLK_PERIOD_NS) < 1) ? 1
                                 : span_cycles(HV_DROP_NS, CLK_PERIOD_NS);

  supply_flags_t cmp_s;
  supply_flags_t good;
  logic          hi_permit;
  logic          hi_gate_q, lo_gate_q, fault_q;

  uvq_sync #(.STAGES(SYNC_STAGES)) u_sync_lv (
    .clk(clk), .rst(rst), .d_i(lv_cmp_ok), .q_o(cmp_s.lv));
  uvq_sync #(.STAGES(SYNC_STAGES)) u_sync_hv (
    .clk(clk), .rst(rst), .d_i(hv_cmp_ok), .q_o(cmp_s.hv));

  uvq_dropout_filter #(.LIMIT(LV_N)) u_filt_lv (
    .clk(clk), .rst(rst), .ok_i(cmp_s.lv), .good_o(good.lv));
  uvq_dropout_filter #(.LIMIT(HV_N)) u_filt_hv (
    .clk(clk), .rst(rst), .ok_i(cmp_s.hv), .good_o(good.hv));

  uvq_hs_arm u_arm (
    .clk(clk), .rst(rst), .hv_good_i(good.hv), .cmd_i(hi_cmd), .permit_o(hi_permit));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_gate_q <= 1'b0;
      lo_gate_q <= 1'b0;
      fault_q   <= 1'b1;
    end else begin
      hi_gate_q <= hi_cmd & hi_permit & good.lv;
      lo_gate_q <= lo_cmd & good.lv;
      fault_q   <= ~good.lv;
    end
  end

  assign hi_gate  = hi_gate_q;
  assign lo_gate  = lo_gate_q;
  assign lv_fault = fault_q;

  AST_LV_LOSS_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    !good.lv |=> (!lo_gate && !hi_gate));   // R2
  AST_HV_LOSS_HI_OFF: assert property (@(posedge clk) disable iff (rst)
    !good.hv |=> !hi_gate);                 // R4
  AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
    !good.lv |=> lv_fault);                 // R8
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    good.lv |=> !lv_fault);                 // R8
  AST_LO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    good.lv |=> (lo_gate == $past(lo_cmd))); // R7, R10

endmodule

// File: tb/tb_dual_supply_uvlo.sv
module tb_dual_supply_uvlo;

  localparam int unsigned PER  = 20;
  localparam int unsigned LV_N = (1500 + PER - 1) / PER;
  localparam int unsigned HV_N = (1300 + PER - 1) / PER;
  localparam int unsigned SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lv_cmp_ok = 1'b0, hv_cmp_ok = 1'b0, hi_cmd = 1'b0, lo_cmd = 1'b0;
  logic hi_gate, lo_gate, lv_fault;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dual_supply_uvlo #(.CLK_PERIOD_NS(PER), .LV_DROP_NS(1500), .HV_DROP_NS(1300),
                     .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .lv_cmp_ok(lv_cmp_ok), .hv_cmp_ok(hv_cmp_ok),
    .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .lv_fault(lv_fault));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: delay queues and bad-run integers.
  bit lvq[$], hvq[$];
  int lv_run, hv_run;
  bit m_lv_good, m_hv_good, m_armed, m_prev, m_lo, m_hi, m_flt;

  always @(posedge clk) begin
    if (rst) begin
      lvq = {}; hvq = {};
      for (int i = 0; i < SYNC; i++) begin lvq.push_back(1'b0); hvq.push_back(1'b0); end
      lv_run = 0; hv_run = 0;
      m_lv_good = 0; m_hv_good = 0; m_armed = 0; m_prev = 0;
      m_lo = 0; m_hi = 0; m_flt = 1;
    end else begin
      bit s_lv, s_hv, edge_seen, ok_hi;
      s_lv = lvq.pop_front(); lvq.push_back(lv_cmp_ok);
      s_hv = hvq.pop_front(); hvq.push_back(hv_cmp_ok);
      edge_seen = hi_cmd && !m_prev;
      ok_hi = m_hv_good && (m_armed || edge_seen);
      m_lo  = lo_cmd && m_lv_good;
      m_hi  = hi_cmd && ok_hi && m_lv_good;
      m_flt = !m_lv_good;
      m_armed = ok_hi;
      m_prev  = hi_cmd;
      if (s_lv) begin m_lv_good = 1; lv_run = 0; end
      else begin lv_run++; if (lv_run >= LV_N) begin m_lv_good = 0; lv_run = LV_N; end end
      if (s_hv) begin m_hv_good = 1; hv_run = 0; end
      else begin hv_run++; if (hv_run >= HV_N) begin m_hv_good = 0; hv_run = HV_N; end end
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 lo_gate vs model", lo_gate, m_lo);
      chk("R6 hi_gate vs model", hi_gate, m_hi);
      chk("R8 lv_fault vs model", lv_fault, m_flt);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  task automatic go(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    go(3);
    chk("R1 hi_gate in reset", hi_gate, 1'b0);
    chk("R1 lo_gate in reset", lo_gate, 1'b0);
    chk("R1 fault in reset", lv_fault, 1'b1);
    rst = 1'b0;
    lv_cmp_ok = 1'b1; hv_cmp_ok = 1'b1; lo_cmd = 1'b1; hi_cmd = 1'b1;
    go(1);
    chk("R1 hi_gate after reset", hi_gate, 1'b0);
    chk("R1 fault after reset", lv_fault, 1'b1);
    go(2);
    chk("R8 fault held during power-up", lv_fault, 1'b1);
    go(1);
    chk("R8 fault released", lv_fault, 1'b0);
    chk("R7 lo_gate takes level at power-up", lo_gate, 1'b1);
    go(5);
    chk("R6 hi held high through power-up stays off", hi_gate, 1'b0);
    hi_cmd = 1'b0; go(2); hi_cmd = 1'b1; go(1);
    chk("R6 hi_gate on after fresh edge", hi_gate, 1'b1);
    lo_cmd = 1'b0; go(1);
    chk("R10 lo_gate follows command", lo_gate, 1'b0);
    lo_cmd = 1'b1; go(1);
    chk("R10 lo_gate follows command high", lo_gate, 1'b1);

    // Logic-supply dips.
    lv_cmp_ok = 1'b0; go(LV_N - 1); lv_cmp_ok = 1'b1; go(6);
    chk("R3 short logic dip ignored lo", lo_gate, 1'b1);
    chk("R3 short logic dip ignored fault", lv_fault, 1'b0);
    lv_cmp_ok = 1'b0; go(LV_N + SYNC);
    chk("R3 lo_gate held before limit", lo_gate, 1'b1);
    go(1);
    chk("R2 lo_gate off on logic UV", lo_gate, 1'b0);
    chk("R2 hi_gate off on logic UV", hi_gate, 1'b0);
    chk("R8 fault on logic UV", lv_fault, 1'b1);
    lv_cmp_ok = 1'b1; go(SYNC + 2);
    chk("R7 lo_gate resumes level", lo_gate, 1'b1);
    chk("R8 fault cleared", lv_fault, 1'b0);

    // High-side dips.
    hv_cmp_ok = 1'b0; go(HV_N - 1); hv_cmp_ok = 1'b1; go(6);
    chk("R5 short high dip ignored", hi_gate, 1'b1);
    hv_cmp_ok = 1'b0; go(HV_N + SYNC);
    chk("R5 hi_gate held before limit", hi_gate, 1'b1);
    go(1);
    chk("R4 hi_gate off on high UV", hi_gate, 1'b0);
    chk("R4 lo_gate unaffected", lo_gate, 1'b1);
    chk("R4 fault unaffected", lv_fault, 1'b0);
    hv_cmp_ok = 1'b1; go(10);
    chk("R6 held command does not re-arm", hi_gate, 1'b0);
    hi_cmd = 1'b0; go(2); hi_cmd = 1'b1; go(1);
    chk("R6 new edge re-arms", hi_gate, 1'b1);

    // One good sample restores the logic supply.
    lv_cmp_ok = 1'b0; go(LV_N + 10);
    chk("R8 fault during long UV", lv_fault, 1'b1);
    lv_cmp_ok = 1'b1; go(1); lv_cmp_ok = 1'b0; go(SYNC + 1);
    chk("R9 single good sample restores", lv_fault, 1'b0);
    chk("R9 lo_gate restored", lo_gate, 1'b1);
    go(LV_N + 10);
    lv_cmp_ok = 1'b1; go(10);
    finish_run();
  end

endmodule